// File: doc/BRIEF.md
# Electrical Link Group Serializer

This block drives the transmit half of one group of up to eight electrical links toward front-end modules. Once per frame it takes a 16-bit word for the group. It spreads that word over the links that the selected rate leaves active and shifts each link's share out serially, most significant bit first. Beside each active data output it drives a forwarded clock whose edges fall at the link's bit rate.

Everything runs from one fast clock, nominally 320 MHz, that is eight times the frame rate. A one-cycle frame strobe marks the start of each frame. A two-bit mode selects the rate:

- At 80 Mb/s, eight links carry 2 bits each.
- At 160 Mb/s, four links carry 4 bits each.
- At 320 Mb/s, two links carry 8 bits each.
- In off mode every output stays quiet.

The mode and the data word are captured only on the strobe, so a mode change takes effect at a frame boundary.

Top module: `elink_group_ser`

## Requirements
- R1: While rst_ni is low, and after its release until the first strobe, every bit of sdata_o and sclk_o is 0.
- R2: With mode code 0 (off) captured, every bit of sdata_o and sclk_o is 0 for the whole frame.
- R3: With mode code 1 (80 Mb/s) captured, links 0..7 are active. Link n sends word bits [15-2n] then [14-2n], each held for 4 cycles.
- R4: With mode code 2 (160 Mb/s) captured, links 0..3 send word bits [15-4n] down to [12-4n], each held for 2 cycles. Links 4..7 stay 0.
- R5: With mode code 3 (320 Mb/s) captured, links 0..1 send word bits [15-8n] down to [8-8n], one per cycle. Links 2..7 stay 0.
- R6: The forwarded clock of an active link is 1 during the even-numbered bits of a frame (0, 2, ...) and 0 during the odd-numbered bits. The forwarded clock of an inactive link is 0.
- R7: mode_i and data_i are sampled only on a clock edge where frame_strobe_i is 1. Changes to either input between strobes have no effect on the outputs until the next strobe.
- R8: The first bit of a frame appears at the outputs right after the clock edge that samples the strobe. Bit k of a 320 Mb/s frame is present k cycles later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock, eight cycles per frame |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_strobe_i | input | 1 | One-cycle pulse at the start of each frame |
| mode_i | input | 2 | Rate select: 0 off, 1 80 Mb/s, 2 160 Mb/s, 3 320 Mb/s |
| data_i | input | 16 | Frame word for the group, captured on the strobe |
| sdata_o | output | 8 | Serial data, one bit per link |
| sclk_o | output | 8 | Forwarded clock, one bit per link |

## Verification
The hardest case to reach from the ports is a mode or data change inside a frame. The block must ignore it until the next strobe, and a faulty design would only show the change mid-frame, not at a boundary. The bench starts an 80 Mb/s frame and, at the fourth cycle, moves mode_i to 320 Mb/s and data_i to a new word while the strobe is low. It then checks that the remaining cycles still follow the word and rate captured on the strobe.

// File: rtl/elink_ser_pkg.sv
package elink_ser_pkg;

  typedef enum logic [1:0] {
    ELINK_OFF  = 2'd0,
    ELINK_R80  = 2'd1,
    ELINK_R160 = 2'd2,
    ELINK_R320 = 2'd3
  } elink_mode_e;

  // log2 of cycles per bit
  function automatic logic [1:0] rate_shift(elink_mode_e m);
    case (m)
      ELINK_R80:  return 2'd2;
      ELINK_R160: return 2'd1;
      default:    return 2'd0;
    endcase
  endfunction

endpackage

// File: rtl/elink_rate_ctrl.sv
module elink_rate_ctrl
  import elink_ser_pkg::*;
#(
  parameter int unsigned CW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          strobe_i,
  input  elink_mode_e   mode_i,
  output elink_mode_e   mode_q_o,
  output logic [CW-1:0] cnt_q_o,
  output logic          shift_o,
  output logic          clk_ph_o
);

  elink_mode_e   mode_q;
  logic [CW-1:0] cnt_q, cnt_nx, mask, bit_idx;
  logic [1:0]    shamt;

  assign shamt   = rate_shift(mode_q);
  assign cnt_nx  = cnt_q + CW'(1);
  assign mask    = (CW'(1) << shamt) - CW'(1);
  assign bit_idx = cnt_q >> shamt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= ELINK_OFF;
      cnt_q  <= '0;
    end else if (strobe_i) begin
      mode_q <= mode_i;
      cnt_q  <= '0;
    end else begin
      cnt_q  <= cnt_nx;
    end
  end

  // shift when the next count starts a new bit
  assign shift_o  = !strobe_i && ((cnt_nx & mask) == '0);
  assign clk_ph_o = ~bit_idx[0];
  assign mode_q_o = mode_q;
  assign cnt_q_o  = cnt_q;

endmodule

// File: rtl/elink_slice_sel.sv
module elink_slice_sel
  import elink_ser_pkg::*;
#(
  parameter int unsigned N_LINKS = 8,
  parameter int unsigned FRAME_W = 16,
  localparam int unsigned BW     = FRAME_W / N_LINKS,
  localparam int unsigned SW     = 4 * BW
) (
  input  elink_mode_e               mode_i,
  input  logic [FRAME_W-1:0]        data_i,
  output logic [N_LINKS-1:0][SW-1:0] slice_o
);

  for (genvar gn = 0; gn < N_LINKS; gn++) begin : g_link
    logic [BW-1:0]   w80;
    logic [2*BW-1:0] w160;
    logic [SW-1:0]   w320;

    assign w80 = data_i[FRAME_W-(gn+1)*BW +: BW];

    if (gn < N_LINKS / 2) begin : g_160
      assign w160 = data_i[FRAME_W-(gn+1)*2*BW +: 2*BW];
    end else begin : g_no160
      assign w160 = '0;
    end

    if (gn < N_LINKS / 4) begin : g_320
      assign w320 = data_i[FRAME_W-(gn+1)*SW +: SW];
    end else begin : g_no320
      assign w320 = '0;
    end

    // left-aligned so the MSB leaves first
    always_comb begin
      case (mode_i)
        ELINK_R80:  slice_o[gn] = {w80, {(SW-BW){1'b0}}};
        ELINK_R160: slice_o[gn] = {w160, {(SW-2*BW){1'b0}}};
        ELINK_R320: slice_o[gn] = w320;
        default:    slice_o[gn] = '0;
      endcase
    end
  end

endmodule

// File: rtl/elink_lane_shift.sv
module elink_lane_shift #(
  parameter int unsigned SW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          shift_i,
  input  logic [SW-1:0] slice_i,
  input  logic          act_i,
  input  logic          clk_ph_i,
  output logic          sdata_o,
  output logic          sclk_o
);

  logic [SW-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sh_q <= '0;
    else if (load_i)  sh_q <= slice_i;
    else if (shift_i) sh_q <= {sh_q[SW-2:0], 1'b0};
  end

  assign sdata_o = act_i & sh_q[SW-1];
  assign sclk_o  = act_i & clk_ph_i;

endmodule

// File: rtl/elink_group_ser.sv
module elink_group_ser
  import elink_ser_pkg::*;
#(
  parameter int unsigned N_LINKS = 8,
  parameter int unsigned FRAME_W = 16,
  localparam int unsigned BW     = FRAME_W / N_LINKS,
  localparam int unsigned SW     = 4 * BW,
  localparam int unsigned CW     = $clog2(SW)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               frame_strobe_i,
  input  logic [1:0]         mode_i,
  input  logic [FRAME_W-1:0] data_i,
  output logic [N_LINKS-1:0] sdata_o,
  output logic [N_LINKS-1:0] sclk_o
);

  elink_mode_e                mode_in, mode_q;
  logic [CW-1:0]              cnt_q;
  logic                       shift, clk_ph;
  logic [N_LINKS-1:0][SW-1:0] slice;

  assign mode_in = elink_mode_e'(mode_i);

  elink_rate_ctrl #(.CW(CW)) u_rate (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .strobe_i (frame_strobe_i),
    .mode_i   (mode_in),
    .mode_q_o (mode_q),
    .cnt_q_o  (cnt_q),
    .shift_o  (shift),
    .clk_ph_o (clk_ph)
  );

  elink_slice_sel #(.N_LINKS(N_LINKS), .FRAME_W(FRAME_W)) u_sel (
    .mode_i  (mode_in),
    .data_i  (data_i),
    .slice_o (slice)
  );

  for (genvar gn = 0; gn < N_LINKS; gn++) begin : g_lane
    logic act;
    assign act = (mode_q == ELINK_R80)
               | ((mode_q == ELINK_R160) && (gn < N_LINKS / 2))
               | ((mode_q == ELINK_R320) && (gn < N_LINKS / 4));

    elink_lane_shift #(.SW(SW)) u_lane (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .load_i   (frame_strobe_i),
      .shift_i  (shift),
      .slice_i  (slice[gn]),
      .act_i    (act),
      .clk_ph_i (clk_ph),
      .sdata_o  (sdata_o[gn]),
      .sclk_o   (sclk_o[gn])
    );
  end

endmodule

// File: rtl/elink_group_ser_chk.sv
module elink_group_ser_chk
  import elink_ser_pkg::*;
#(
  parameter int unsigned N_LINKS = 8,
  parameter int unsigned CW      = 3
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               frame_strobe_i,
  input logic [1:0]         mode_i,
  input logic [N_LINKS-1:0] sdata_o,
  input logic [N_LINKS-1:0] sclk_o,
  input elink_mode_e        mode_q,
  input logic [CW-1:0]      cnt_q
);

  // R2
  off_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == ELINK_OFF) |-> (sdata_o == '0 && sclk_o == '0));

  // R4
  r160_upper_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == ELINK_R160) |->
      (sdata_o[N_LINKS-1:N_LINKS/2] == '0 && sclk_o[N_LINKS-1:N_LINKS/2] == '0));

  // R5
  r320_upper_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == ELINK_R320) |->
      (sdata_o[N_LINKS-1:N_LINKS/4] == '0 && sclk_o[N_LINKS-1:N_LINKS/4] == '0));

  // R7
  mode_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(frame_strobe_i) |-> $stable(mode_q));

  // R7
  mode_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_strobe_i |=> (mode_q == elink_mode_e'($past(mode_i))));

  // R3
  r80_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == ELINK_R80 && cnt_q[1:0] != 2'd0) |-> $stable(sdata_o));

  // R6
  r320_toggle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == ELINK_R320 && $past(mode_q) == ELINK_R320 && !$past(frame_strobe_i))
      |-> (sclk_o[0] != $past(sclk_o[0])));

endmodule

bind elink_group_ser elink_group_ser_chk #(.N_LINKS(N_LINKS), .CW(CW)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .frame_strobe_i (frame_strobe_i),
  .mode_i         (mode_i),
  .sdata_o        (sdata_o),
  .sclk_o         (sclk_o),
  .mode_q         (mode_q),
  .cnt_q          (cnt_q)
);

// File: tb/elink_group_ser_bench.sv
module elink_group_ser_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        strobe = 1'b0;
  logic [1:0]  mode_in = 2'd0;
  logic [15:0] data_in = '0;
  logic [7:0]  sdata, sclk;
  int          n_checks = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  elink_group_ser u_elink_group_ser (
    .clk_i          (clk),
    .rst_ni         (rst_n),
    .frame_strobe_i (strobe),
    .mode_i         (mode_in),
    .data_i         (data_in),
    .sdata_o        (sdata),
    .sclk_o         (sclk)
  );

  // {mode, word}
  localparam logic [17:0] VEC [7] = '{
    {2'd1, 16'hA5C3}, {2'd2, 16'h1234}, {2'd3, 16'hF00F}, {2'd3, 16'h8001},
    {2'd1, 16'hFFFF}, {2'd2, 16'h6B9E}, {2'd0, 16'hFFFF}
  };

  function automatic void rate_of(input logic [1:0] m, output int w, output int s);
    case (m)
      2'd1: begin w = 2; s = 2; end
      2'd2: begin w = 4; s = 1; end
      2'd3: begin w = 8; s = 0; end
      default: begin w = 0; s = 0; end
    endcase
  endfunction

  function automatic logic [7:0] exp_data(logic [1:0] m, logic [15:0] d, int k);
    int w, s;
    logic [7:0] r = '0;
    rate_of(m, w, s);
    if (w == 0) return '0;
    for (int n = 0; n < 16 / w; n++) r[n] = d[15 - n*w - (k >> s)];
    return r;
  endfunction

  function automatic logic [7:0] exp_clk(logic [1:0] m, int k);
    int w, s;
    logic [7:0] r = '0;
    rate_of(m, w, s);
    if (w == 0) return '0;
    for (int n = 0; n < 16 / w; n++) r[n] = (((k >> s) % 2) == 0);
    return r;
  endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  function automatic string mode_tag(logic [1:0] m);
    case (m)
      2'd0: return "R2";
      2'd1: return "R3";
      2'd2: return "R4";
      default: return "R5";
    endcase
  endfunction

  // caller stands at a negedge; strobes now, checks 8 cycles
  task automatic run_frame(logic [1:0] m, logic [15:0] d, bit chg,
                           logic [1:0] am, logic [15:0] ad);
    strobe  = 1'b1;
    mode_in = m;
    data_in = d;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      strobe = 1'b0;
      if (chg && k == 3) begin
        mode_in = am;
        data_in = ad;
      end
      chk($sformatf("%s%s%s data m=%0d k=%0d", mode_tag(m), chg ? " R7" : "",
                    k == 0 ? " R8" : "", m, k), sdata, exp_data(m, d, k));
      chk($sformatf("R6%s clock m=%0d k=%0d", chg ? " R7" : "", m, k),
          sclk, exp_clk(m, k));
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    // R1 during reset
    repeat (3) @(negedge clk);
    chk("R1 reset data", sdata, 8'h00);
    chk("R1 reset clock", sclk, 8'h00);
    rst_n = 1'b1;
    // R1 no strobe yet
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk("R1 idle data", sdata, 8'h00);
      chk("R1 idle clock", sclk, 8'h00);
    end

    for (int v = 0; v < 7; v++)
      run_frame(VEC[v][17:16], VEC[v][15:0], 1'b0, 2'd0, '0);

    // R7 mid-frame change of rate and word is ignored
    run_frame(2'd1, 16'h3C96, 1'b1, 2'd3, 16'hFFFF);
    run_frame(2'd2, 16'hC35A, 1'b1, 2'd0, 16'h0000);
    run_frame(2'd0, 16'hFFFF, 1'b1, 2'd1, 16'hFFFF);
    // back-to-back rate switch at a boundary
    run_frame(2'd3, 16'hA55A, 1'b0, 2'd0, '0);
    run_frame(2'd1, 16'h5AA5, 1'b0, 2'd0, '0);

    // R1 asynchronous reset mid-frame
    strobe  = 1'b1;
    mode_in = 2'd3;
    data_in = 16'hFFFF;
    @(negedge clk);
    strobe = 1'b0;
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R1 async reset data", sdata, 8'h00);
    chk("R1 async reset clock", sclk, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    run_frame(2'd3, 16'h0FF0, 1'b0, 2'd0, '0);

    summary();
  end

endmodule